// File: doc/BRIEF.md
# Real-Time Clock Update Engine

This block keeps time of day and a calendar in ten byte registers: seconds, minutes and hours, each with an alarm byte, plus day of week, date, month and year. Software reaches these bytes and three control bytes through an indexed register port with an index, a write strobe, write data, a read strobe and combinational read data. A prescaled `tick` input stands in for the oscillator. An internal divider counts these ticks. Once per second it issues an update that advances the time and calendar chain in one step.

A single mode bit decides whether all ten bytes are read as binary or as packed BCD. Changing this bit never rewrites the stored bytes. A 3-bit oscillator field must hold 010b for the divider to run. When that value is written, the divider restarts half a second before its terminal count, so the first update comes half a second after the write. An inhibit bit lets software load the time without the block advancing it. After each update the seconds, minutes and hours are compared with their alarm bytes, and a match sets a flag. Reading the status byte clears that flag.

Top module: `rtc_core`

## Requirements
- R1: After reset, all ten data bytes and control A read 0x00, control B reads 0x80 (updates inhibited, BCD), the status byte reads 0x00 and `alarm_flag` is low.
- R2: Register map: index 0 seconds, 1 seconds alarm, 2 minutes, 3 minutes alarm, 4 hours, 5 hours alarm, 6 day of week, 7 date, 8 month, 9 year. Index 10 is control A, with the oscillator field in bits 6:4. Index 11 is control B, with bit 7 the inhibit bit and bit 2 the mode bit (1 = binary, 0 = BCD). Index 12 is status, with bit 7 the alarm flag. Writes to these registers read back.
- R3: While the oscillator field holds any value other than 010b, the divider is held and no update occurs, however many ticks arrive.
- R4: Writing 010b to the oscillator field makes the first update follow after TICKS_PER_SEC/2 ticks. Later updates follow every TICKS_PER_SEC ticks.
- R5: While the inhibit bit is 1, updates do not change any byte. A second boundary reached while inhibited is discarded and is not applied when the inhibit bit is cleared.
- R6: An update increments seconds 0–59 with carry into minutes 0–59 and hours 0–23, in the selected mode. In BCD, 0x09 is followed by 0x10. In binary, 9 is followed by 0x0A.
- R7: An hour carry advances the day of week (7 wraps to 1) and the date. The date wraps to 1 after the month's last day: 30 days for months 4, 6, 9 and 11; 28 days for month 2, or 29 when the year value is divisible by 4; 31 days otherwise. The month wraps 12 to 1 with a carry into the year, and the year wraps 99 to 0.
- R8: Changing the mode bit leaves the stored bytes unchanged. Later updates interpret the same bytes in the new mode.
- R9: If, after an update, seconds, minutes and hours equal their alarm bytes, the alarm flag sets (status bit 7 and `alarm_flag`). A read of the status byte clears it. A non-matching update does not set it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| tick | input | 1 | Prescaled oscillator tick, one-cycle pulse |
| reg_idx | input | 4 | Register index |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe (clears the alarm flag on a status read) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_idx`, combinational |
| alarm_flag | output | 1 | Alarm flag level |

## Verification
The bench builds the block with TICKS_PER_SEC set to 4. This makes half a second two ticks and a full second four ticks. As a result, the phase of the first update after an oscillator write, the held divider, and a second boundary dropped under inhibit can each be observed within a few ticks. Every calendar rollover is reached by loading the bytes just before the boundary and applying one update. This covers year end, leap and non-leap February, and 30-day months, in both modes.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int NUM_DATA = 10;

  localparam logic [3:0] IX_SEC  = 4'd0;
  localparam logic [3:0] IX_ASEC = 4'd1;
  localparam logic [3:0] IX_MIN  = 4'd2;
  localparam logic [3:0] IX_AMIN = 4'd3;
  localparam logic [3:0] IX_HR   = 4'd4;
  localparam logic [3:0] IX_AHR  = 4'd5;
  localparam logic [3:0] IX_DOW  = 4'd6;
  localparam logic [3:0] IX_DATE = 4'd7;
  localparam logic [3:0] IX_MON  = 4'd8;
  localparam logic [3:0] IX_YR   = 4'd9;
  localparam logic [3:0] IX_CTLA = 4'd10;
  localparam logic [3:0] IX_CTLB = 4'd11;
  localparam logic [3:0] IX_STAT = 4'd12;

  localparam logic [2:0] OSC_RUN = 3'b010;

  typedef logic [NUM_DATA-1:0][7:0] data_bank_t;

  // stored byte -> plain binary value
  function automatic logic [7:0] dec_val(input logic [7:0] b, input logic bin);
    logic [7:0] tens;
    tens = {4'd0, b[7:4]};
    return bin ? b : (tens * 8'd10 + {4'd0, b[3:0]});
  endfunction

  // plain binary value -> stored byte
  function automatic logic [7:0] enc_val(input logic [7:0] v, input logic bin);
    logic [7:0] t;
    logic [7:0] u;
    t = v / 8'd10;
    u = v % 8'd10;
    return bin ? v : {t[3:0], u[3:0]};
  endfunction

  function automatic logic [7:0] days_in(input logic [7:0] mon, input logic [7:0] yr);
    logic [7:0] d;
    case (mon)
      8'd2:                   d = ((yr % 8'd4) == 8'd0) ? 8'd29 : 8'd28;
      8'd4, 8'd6, 8'd9, 8'd11: d = 8'd30;
      default:                d = 8'd31;
    endcase
    return d;
  endfunction
endpackage

// File: rtl/rtc_divider.sv
module rtc_divider #(
  parameter int TICKS_PER_SEC = 32768
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic run,
  output logic sec_pulse
);
  localparam int CW = (TICKS_PER_SEC > 2) ? $clog2(TICKS_PER_SEC) : 1;
  localparam logic [CW-1:0] HALF = CW'(TICKS_PER_SEC / 2);
  localparam logic [CW-1:0] LAST = CW'(TICKS_PER_SEC - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          pulse_q, pulse_d;

  always_comb begin
    cnt_d   = cnt_q;
    pulse_d = 1'b0;
    if (!run) begin
      cnt_d = HALF;
    end else if (tick) begin
      if (cnt_q == LAST) begin
        cnt_d   = '0;
        pulse_d = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= HALF;
      pulse_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      pulse_q <= pulse_d;
    end
  end

  assign sec_pulse = pulse_q;

  // R3
  sec_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sec_pulse |-> ($past(run) && $past(tick)));
endmodule

// File: rtl/rtc_timekeep.sv
module rtc_timekeep
  import rtc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       adv,
  input  logic       bin,
  input  logic       wr_en,
  input  logic [3:0] wr_idx,
  input  logic [7:0] wr_data,
  output data_bank_t regs,
  output logic       upd_done
);
  data_bank_t regs_q, regs_d;
  logic       upd_q;

  logic [7:0] v_s, v_m, v_h, v_dw, v_dt, v_mo, v_y, md;
  logic [7:0] n_s, n_m, n_h, n_dw, n_dt, n_mo, n_y;
  logic       c_s, c_m, c_h, c_d, c_mo;

  always_comb begin
    v_s  = dec_val(regs_q[IX_SEC],  bin);
    v_m  = dec_val(regs_q[IX_MIN],  bin);
    v_h  = dec_val(regs_q[IX_HR],   bin);
    v_dw = dec_val(regs_q[IX_DOW],  bin);
    v_dt = dec_val(regs_q[IX_DATE], bin);
    v_mo = dec_val(regs_q[IX_MON],  bin);
    v_y  = dec_val(regs_q[IX_YR],   bin);
    md   = days_in(v_mo, v_y);

    c_s  = (v_s >= 8'd59);
    n_s  = c_s ? 8'd0 : v_s + 8'd1;
    c_m  = c_s && (v_m >= 8'd59);
    n_m  = c_s ? ((v_m >= 8'd59) ? 8'd0 : v_m + 8'd1) : v_m;
    c_h  = c_m && (v_h >= 8'd23);
    n_h  = c_m ? ((v_h >= 8'd23) ? 8'd0 : v_h + 8'd1) : v_h;
    n_dw = c_h ? ((v_dw >= 8'd7) ? 8'd1 : v_dw + 8'd1) : v_dw;
    c_d  = c_h && (v_dt >= md);
    n_dt = c_h ? ((v_dt >= md) ? 8'd1 : v_dt + 8'd1) : v_dt;
    c_mo = c_d && (v_mo >= 8'd12);
    n_mo = c_d ? ((v_mo >= 8'd12) ? 8'd1 : v_mo + 8'd1) : v_mo;
    n_y  = c_mo ? ((v_y >= 8'd99) ? 8'd0 : v_y + 8'd1) : v_y;

    regs_d = regs_q;
    if (adv) begin
      regs_d[IX_SEC]  = enc_val(n_s,  bin);
      regs_d[IX_MIN]  = enc_val(n_m,  bin);
      regs_d[IX_HR]   = enc_val(n_h,  bin);
      regs_d[IX_DOW]  = enc_val(n_dw, bin);
      regs_d[IX_DATE] = enc_val(n_dt, bin);
      regs_d[IX_MON]  = enc_val(n_mo, bin);
      regs_d[IX_YR]   = enc_val(n_y,  bin);
    end
    if (wr_en && (wr_idx <= IX_YR)) begin
      regs_d[wr_idx] = wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      regs_q <= '0;
      upd_q  <= 1'b0;
    end else begin
      regs_q <= regs_d;
      upd_q  <= adv;
    end
  end

  assign regs     = regs_q;
  assign upd_done = upd_q;

  // R5
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv && !wr_en) |=> $stable(regs_q));

  // R6
  sec_moves_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !wr_en) |=> (regs_q[IX_SEC] != $past(regs_q[IX_SEC])));
endmodule

// File: rtl/rtc_alarm.sv
module rtc_alarm (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       upd_done,
  input  logic [7:0] cur_s,
  input  logic [7:0] cur_m,
  input  logic [7:0] cur_h,
  input  logic [7:0] al_s,
  input  logic [7:0] al_m,
  input  logic [7:0] al_h,
  input  logic       clr,
  output logic       flag
);
  logic flag_q, flag_d;
  logic hit;

  always_comb begin
    hit    = (cur_s == al_s) && (cur_m == al_m) && (cur_h == al_h);
    flag_d = flag_q;
    if (clr) flag_d = 1'b0;
    if (upd_done && hit) flag_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

  assign flag = flag_q;

  // R9
  alarm_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> $past(upd_done));
endmodule

// File: rtl/rtc_core.sv
module rtc_core
  import rtc_pkg::*;
#(
  parameter int TICKS_PER_SEC = 32768
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic [3:0] reg_idx,
  input  logic       reg_wr,
  input  logic       reg_rd,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       alarm_flag
);
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic [2:0] osc_q, osc_d;
  logic       inh_q, inh_d;
  logic       bin_q, bin_d;

  always_comb begin
    osc_d = osc_q;
    inh_d = inh_q;
    bin_d = bin_q;
    if (reg_wr && reg_idx == IX_CTLA) osc_d = reg_wdata[6:4];
    if (reg_wr && reg_idx == IX_CTLB) begin
      inh_d = reg_wdata[7];
      bin_d = reg_wdata[2];
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      osc_q <= 3'b000;
      inh_q <= 1'b1;
      bin_q <= 1'b0;
    end else begin
      osc_q <= osc_d;
      inh_q <= inh_d;
      bin_q <= bin_d;
    end
  end

  logic       sec_pulse;
  logic       adv;
  logic       upd_done;
  logic       flag;
  data_bank_t regs;

  rtc_divider #(.TICKS_PER_SEC(TICKS_PER_SEC)) u_div (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .tick      (tick),
    .run       (osc_q == OSC_RUN),
    .sec_pulse (sec_pulse)
  );

  assign adv = sec_pulse && !inh_q;

  rtc_timekeep u_tk (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .adv      (adv),
    .bin      (bin_q),
    .wr_en    (reg_wr),
    .wr_idx   (reg_idx),
    .wr_data  (reg_wdata),
    .regs     (regs),
    .upd_done (upd_done)
  );

  rtc_alarm u_alm (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .upd_done (upd_done),
    .cur_s    (regs[IX_SEC]),
    .cur_m    (regs[IX_MIN]),
    .cur_h    (regs[IX_HR]),
    .al_s     (regs[IX_ASEC]),
    .al_m     (regs[IX_AMIN]),
    .al_h     (regs[IX_AHR]),
    .clr      (reg_rd && (reg_idx == IX_STAT)),
    .flag     (flag)
  );

  always_comb begin
    reg_rdata = 8'h00;
    if (reg_idx <= IX_YR)        reg_rdata = regs[reg_idx];
    else if (reg_idx == IX_CTLA) reg_rdata = {1'b0, osc_q, 4'b0000};
    else if (reg_idx == IX_CTLB) reg_rdata = {inh_q, 4'b0000, bin_q, 2'b00};
    else if (reg_idx == IX_STAT) reg_rdata = {flag, 7'b0000000};
  end

  assign alarm_flag = flag;
endmodule

// File: tb/tb_rtc_core.sv
module tb_rtc_core;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic [3:0] reg_idx = 4'd0;
  logic       reg_wr = 1'b0;
  logic       reg_rd = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       alarm_flag;

  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  rtc_core #(.TICKS_PER_SEC(4)) dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .reg_idx(reg_idx),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .alarm_flag(alarm_flag)
  );

  // {mode, s, m, h, dow, date, mon, yr, exp s, m, h, dow, date, mon, yr}
  localparam logic [119:0] VEC [0:7] = '{
    {8'h00, 8'h59,8'h59,8'h23,8'h07,8'h31,8'h12,8'h99, 8'h00,8'h00,8'h00,8'h01,8'h01,8'h01,8'h00},
    {8'h01, 8'h3B,8'h3B,8'h17,8'h03,8'h1C,8'h02,8'h17, 8'h00,8'h00,8'h00,8'h04,8'h01,8'h03,8'h17},
    {8'h01, 8'h3B,8'h3B,8'h17,8'h05,8'h1C,8'h02,8'h18, 8'h00,8'h00,8'h00,8'h06,8'h1D,8'h02,8'h18},
    {8'h00, 8'h59,8'h59,8'h23,8'h02,8'h29,8'h02,8'h24, 8'h00,8'h00,8'h00,8'h03,8'h01,8'h03,8'h24},
    {8'h00, 8'h09,8'h45,8'h13,8'h05,8'h15,8'h06,8'h07, 8'h10,8'h45,8'h13,8'h05,8'h15,8'h06,8'h07},
    {8'h01, 8'h09,8'h2D,8'h0D,8'h05,8'h0F,8'h06,8'h07, 8'h0A,8'h2D,8'h0D,8'h05,8'h0F,8'h06,8'h07},
    {8'h00, 8'h59,8'h59,8'h23,8'h04,8'h30,8'h04,8'h11, 8'h00,8'h00,8'h00,8'h05,8'h01,8'h05,8'h11},
    {8'h01, 8'h3B,8'h3B,8'h05,8'h01,8'h0A,8'h0B,8'h30, 8'h00,8'h00,8'h06,8'h01,8'h0A,8'h0B,8'h30}
  };
  localparam logic [3:0] FIDX [0:6] = '{4'd0, 4'd2, 4'd4, 4'd6, 4'd7, 4'd8, 4'd9};

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] idx, input logic [7:0] d);
    @(negedge clk);
    reg_idx = idx; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] idx, output logic [7:0] v);
    @(negedge clk);
    reg_idx = idx; reg_rd = 1'b1;
    #1 v = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
      repeat (4) @(negedge clk);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog got=timeout exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] v;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    for (int i = 0; i < 10; i++) begin
      rd(4'(i), v); chk("R1 data", v, 8'h00);
    end
    rd(4'd10, v); chk("R1 ctlA", v, 8'h00);
    rd(4'd11, v); chk("R1 ctlB", v, 8'h80);
    rd(4'd12, v); chk("R1 stat", v, 8'h00);
    chk("R1 flag", {7'd0, alarm_flag}, 8'h00);

    // R6 R7 vector walk
    for (int k = 0; k < 8; k++) begin
      logic [7:0] mb;
      mb = {5'd0, VEC[k][112], 2'b00};
      wr(4'd10, 8'h00);
      wr(4'd11, 8'h80 | mb);
      for (int f = 0; f < 7; f++) wr(FIDX[f], VEC[k][111-8*f -: 8]);
      wr(4'd11, mb);
      rd(4'd11, v); chk("R2 ctlB", v, mb);
      wr(4'd10, 8'h20);
      ticks(2);
      for (int f = 0; f < 7; f++) begin
        rd(FIDX[f], v);
        chk((f < 3) ? "R6 vec" : "R7 vec", v, VEC[k][55-8*f -: 8]);
      end
    end

    // R3 divider held when field is not 010b
    wr(4'd11, 8'h84);
    wr(4'd0, 8'h05);
    wr(4'd11, 8'h04);
    wr(4'd10, 8'h30);
    rd(4'd10, v); chk("R2 ctlA", v, 8'h30);
    ticks(8);
    rd(4'd0, v); chk("R3 held", v, 8'h05);

    // R4 half-second first update, then full seconds
    wr(4'd10, 8'h20);
    ticks(1); rd(4'd0, v); chk("R4 early", v, 8'h05);
    ticks(1); rd(4'd0, v); chk("R4 first", v, 8'h06);
    ticks(3); rd(4'd0, v); chk("R4 gap", v, 8'h06);
    ticks(1); rd(4'd0, v); chk("R4 second", v, 8'h07);

    // R5 inhibit drops the boundary
    wr(4'd11, 8'h84);
    ticks(4); rd(4'd0, v); chk("R5 inhibited", v, 8'h07);
    wr(4'd11, 8'h04);
    repeat (5) @(negedge clk);
    rd(4'd0, v); chk("R5 not queued", v, 8'h07);
    ticks(4); rd(4'd0, v); chk("R5 resume", v, 8'h08);

    // R8 mode change leaves bytes alone
    wr(4'd11, 8'h80);
    wr(4'd0, 8'h19);
    wr(4'd11, 8'h84);
    rd(4'd0, v); chk("R8 no convert", v, 8'h19);
    wr(4'd11, 8'h04);
    wr(4'd10, 8'h00);
    wr(4'd10, 8'h20);
    ticks(2); rd(4'd0, v); chk("R8 binary count", v, 8'h1A);

    // R9 alarm match
    wr(4'd11, 8'h84);
    wr(4'd0, 8'd29); wr(4'd2, 8'd20); wr(4'd4, 8'd10);
    wr(4'd1, 8'd30); wr(4'd3, 8'd20); wr(4'd5, 8'd10);
    rd(4'd12, v);
    chk("R9 cleared", {7'd0, alarm_flag}, 8'h00);
    wr(4'd11, 8'h04);
    wr(4'd10, 8'h00);
    wr(4'd10, 8'h20);
    ticks(2);
    chk("R9 pin set", {7'd0, alarm_flag}, 8'h01);
    rd(4'd12, v); chk("R9 status set", v, 8'h80);
    rd(4'd12, v); chk("R9 read clears", v, 8'h00);
    chk("R9 pin clear", {7'd0, alarm_flag}, 8'h00);
    ticks(4);
    rd(4'd0, v); chk("R9 sec", v, 8'd31);
    rd(4'd12, v); chk("R9 no match", v, 8'h00);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule